// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Vector Generation

This block decides which pending interrupt the processor takes next and gives the address of that source's vector. Five fixed sources cannot be masked: a reset request, a debug break, the watchdog, a zero-divide trap and a break-instruction trap. They rank above a set of maskable sources. Each maskable source comes with a 3-bit priority level written by software. A maskable source is eligible only when the global interrupt-disable flag is clear and its level is strictly above the processor's current priority level.

The processor raises `take_en` at a point where it can accept an interrupt. On the next clock edge the block registers its decision. It then shows a one-cycle `take` strobe, the 24-bit vector address, and a one-cycle acknowledge on the line of the winning source. The source uses that acknowledge to clear its own request bit. The block holds off for one cycle after each take, so a request being cleared is never taken twice.

Top module: `irq_vec_arbiter`

## Requirements
- R1: While `rst` is high, and after it, until the first take: `take`, `vec_addr`, `mask_ack` and `fix_ack` are all zero.
- R2: The fixed sources rank as follows: reset request, then debug, then watchdog, then zero divide, then break, then all maskable sources. A fixed source is taken whatever the values of `irq_dis` and `cur_ipl`.
- R3: A maskable source is taken only when `irq_dis` is 0 and its level is strictly greater than `cur_ipl`, so a level of 0 is never taken.
- R4: Among eligible maskable sources, the highest level wins. On equal levels, the lower index wins; that index has the higher vector address.
- R5: The low 16 bits of the vector address are fixed per source: reset 0xFFFE, zero divide 0xFFFC, break 0xFFFA, debug 0xFFF8, watchdog 0xFFF6, and maskable index i gets 0xFFF4 − 2·i. Index 0 is external line 0 and index 15 is the shared converter/serial source at 0xFFD6. Bits 23:16 are 0x00.
- R6: A decision is made at a clock edge where `take_en` is 1 and `take` is 0. The results appear on the outputs after that edge for exactly one cycle. `take` is never high on two consecutive cycles.
- R7: Exactly one acknowledge bit is high in the `take` cycle, and only for the winner. For maskable source i this is `mask_ack[i]`. `fix_ack` uses bit 0 for reset, bit 1 for debug, bit 2 for watchdog, bit 3 for zero divide and bit 4 for break. No acknowledge is high outside a take cycle.
- R8: While `take_en` is 0, no take occurs, whatever the pending requests.
- R9: `vec_addr` keeps its value in every cycle where `take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_en | input | 1 | Processor can accept an interrupt |
| irq_dis | input | 1 | Global maskable-interrupt disable |
| cur_ipl | input | 3 | Current processor priority level |
| rst_req | input | 1 | Reset-source request |
| dbg_req | input | 1 | Debug break request |
| wdt_req | input | 1 | Watchdog request |
| zdiv_req | input | 1 | Zero-divide trap request |
| brk_req | input | 1 | Break-instruction trap request |
| mask_req | input | N_SRC | Maskable request bits |
| mask_lvl | input | 3·N_SRC | Level of source i in bits 3i+2:3i |
| take | output | 1 | One-cycle interrupt-take strobe |
| vec_addr | output | 24 | Address of the winner's vector pair |
| mask_ack | output | N_SRC | One-cycle acknowledge to a maskable winner |
| fix_ack | output | 5 | One-cycle acknowledge to a fixed winner |

## Verification
Every cycle, the assertions check these properties:
- at most one acknowledge is high, and one is high exactly when `take` is;
- `take` never repeats on consecutive cycles;
- the vector stays stable and even, with a zero bank byte;
- no maskable acknowledge follows a cycle with `irq_dis` set;
- a pending reset request always wins the next take.

Only the directed scenarios can show the rest:
- the full fixed ranking, walked down one source at a time;
- the level comparison against `cur_ipl`;
- tie-breaking between equal levels;
- the exact vector of every maskable index.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W = 3;
    localparam int IDX_W = 6;
    localparam int NFIX  = 5;

    // fixed acknowledge bit positions
    localparam int FA_RESET = 0;
    localparam int FA_DEBUG = 1;
    localparam int FA_WDT   = 2;
    localparam int FA_ZDIV  = 3;
    localparam int FA_BRK   = 4;

    typedef enum logic [2:0] {
        K_NONE,
        K_RESET,
        K_DEBUG,
        K_WDT,
        K_ZDIV,
        K_BRK,
        K_MASK
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [IDX_W-1:0]  idx;
        logic [LVL_W-1:0]  lvl;
    } pick_t;

    localparam pick_t PICK_NONE = '{kind: K_NONE, idx: '0, lvl: '0};

    function automatic logic [15:0] vec_low(input pick_t p, input logic [15:0] mask_top);
        case (p.kind)
            K_RESET: return 16'hFFFE;
            K_ZDIV:  return 16'hFFFC;
            K_BRK:   return 16'hFFFA;
            K_DEBUG: return 16'hFFF8;
            K_WDT:   return 16'hFFF6;
            K_MASK:  return 16'(mask_top - 16'({p.idx, 1'b0}));
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [NFIX-1:0] fix_onehot(input kind_e k);
        logic [NFIX-1:0] r;
        r = '0;
        case (k)
            K_RESET: r[FA_RESET] = 1'b1;
            K_DEBUG: r[FA_DEBUG] = 1'b1;
            K_WDT:   r[FA_WDT]   = 1'b1;
            K_ZDIV:  r[FA_ZDIV]  = 1'b1;
            K_BRK:   r[FA_BRK]   = 1'b1;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_mask_pick.sv
module irq_mask_pick
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]       ipl,
    input  logic                   dis,
    output pick_t                  pick
);

    logic [N_SRC-1:0] elig;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = req[g] && !dis && (lvl[g*LVL_W +: LVL_W] > ipl);
    end

    // ascending scan, strict compare: the lowest index keeps a tie
    always_comb begin
        pick = PICK_NONE;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (pick.kind == K_NONE || lvl[i*LVL_W +: LVL_W] > pick.lvl)) begin
                pick.kind = K_MASK;
                pick.idx  = IDX_W'(i);
                pick.lvl  = lvl[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_fixed_tier.sv
module irq_fixed_tier
    import irq_arb_pkg::*;
(
    input  logic  rst_req,
    input  logic  dbg_req,
    input  logic  wdt_req,
    input  logic  zdiv_req,
    input  logic  brk_req,
    input  pick_t mask_pick,
    output pick_t win
);

    always_comb begin
        win = PICK_NONE;
        if (rst_req)       win.kind = K_RESET;
        else if (dbg_req)  win.kind = K_DEBUG;
        else if (wdt_req)  win.kind = K_WDT;
        else if (zdiv_req) win.kind = K_ZDIV;
        else if (brk_req)  win.kind = K_BRK;
        else               win = mask_pick;
    end

endmodule

// File: rtl/irq_take_reg.sv
module irq_take_reg
    import irq_arb_pkg::*;
#(
    parameter int          N_SRC    = 16,
    parameter logic [15:0] MASK_TOP = 16'hFFF4,
    parameter logic [7:0]  BANK     = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_en,
    input  pick_t            win,
    output logic             take,
    output logic [23:0]      vec_addr,
    output logic [N_SRC-1:0] mask_ack,
    output logic [NFIX-1:0]  fix_ack
);

    logic go;
    assign go = take_en && !take && (win.kind != K_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            vec_addr <= '0;
            mask_ack <= '0;
            fix_ack  <= '0;
        end else begin
            take     <= go;
            mask_ack <= '0;
            fix_ack  <= '0;
            if (go) begin
                vec_addr <= {BANK, vec_low(win, MASK_TOP)};
                if (win.kind == K_MASK) mask_ack <= N_SRC'(1) << win.idx;
                else                    fix_ack  <= fix_onehot(win.kind);
            end
        end
    end

    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mask_ack, fix_ack}));
    p_ack_with_take_r7: assert property (@(posedge clk) disable iff (rst)
        take == ($countones({mask_ack, fix_ack}) == 1));
    p_no_double_take_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !take |-> $stable(vec_addr));
    p_vec_shape_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (vec_addr[23:16] == BANK && !vec_addr[0]));

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
    import irq_arb_pkg::*;
#(
    parameter int          N_SRC    = 16,
    parameter logic [15:0] MASK_TOP = 16'hFFF4,
    parameter logic [7:0]  BANK     = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   take_en,
    input  logic                   irq_dis,
    input  logic [LVL_W-1:0]       cur_ipl,
    input  logic                   rst_req,
    input  logic                   dbg_req,
    input  logic                   wdt_req,
    input  logic                   zdiv_req,
    input  logic                   brk_req,
    input  logic [N_SRC-1:0]       mask_req,
    input  logic [N_SRC*LVL_W-1:0] mask_lvl,
    output logic                   take,
    output logic [23:0]            vec_addr,
    output logic [N_SRC-1:0]       mask_ack,
    output logic [NFIX-1:0]        fix_ack
);

    pick_t m_pick;
    pick_t f_win;

    irq_mask_pick #(.N_SRC(N_SRC)) u_mask (
        .req  (mask_req),
        .lvl  (mask_lvl),
        .ipl  (cur_ipl),
        .dis  (irq_dis),
        .pick (m_pick)
    );

    irq_fixed_tier u_fixed (
        .rst_req   (rst_req),
        .dbg_req   (dbg_req),
        .wdt_req   (wdt_req),
        .zdiv_req  (zdiv_req),
        .brk_req   (brk_req),
        .mask_pick (m_pick),
        .win       (f_win)
    );

    irq_take_reg #(.N_SRC(N_SRC), .MASK_TOP(MASK_TOP), .BANK(BANK)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .take_en  (take_en),
        .win      (f_win),
        .take     (take),
        .vec_addr (vec_addr),
        .mask_ack (mask_ack),
        .fix_ack  (fix_ack)
    );

    p_dis_blocks_mask_r3: assert property (@(posedge clk) disable iff (rst)
        irq_dis |=> (mask_ack == '0));
    p_reset_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (take_en && !take && rst_req) |=> (take && vec_addr[15:0] == 16'hFFFE && fix_ack[FA_RESET]));
    p_no_take_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        !take_en |=> !take);

endmodule

// File: tb/tb_irq_vec_arbiter.sv
module tb_irq_vec_arbiter;

    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          take_en = 1'b0;
    logic          irq_dis = 1'b0;
    logic [2:0]    cur_ipl = '0;
    logic          rst_req = 1'b0, dbg_req = 1'b0, wdt_req = 1'b0, zdiv_req = 1'b0, brk_req = 1'b0;
    logic [N-1:0]  mask_req = '0;
    logic [N*3-1:0] mask_lvl = '0;
    logic          take;
    logic [23:0]   vec_addr;
    logic [N-1:0]  mask_ack;
    logic [4:0]    fix_ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_vec_arbiter #(.N_SRC(N)) dut (
        .clk(clk), .rst(rst), .take_en(take_en), .irq_dis(irq_dis), .cur_ipl(cur_ipl),
        .rst_req(rst_req), .dbg_req(dbg_req), .wdt_req(wdt_req), .zdiv_req(zdiv_req),
        .brk_req(brk_req), .mask_req(mask_req), .mask_lvl(mask_lvl),
        .take(take), .vec_addr(vec_addr), .mask_ack(mask_ack), .fix_ack(fix_ack)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        rst_req = 0; dbg_req = 0; wdt_req = 0; zdiv_req = 0; brk_req = 0;
        mask_req = '0; mask_lvl = '0; irq_dis = 0; cur_ipl = '0; take_en = 0;
    endtask

    task automatic set_src(input int i, input logic [2:0] l);
        mask_req[i] = 1'b1;
        mask_lvl[i*3 +: 3] = l;
    endtask

    // one decision edge, then sample, then one idle edge
    task automatic step_take();
        take_en = 1'b1;
        @(posedge clk); @(negedge clk);
        take_en = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic expect_take(input string tag, input logic [15:0] lo,
                               input logic [N-1:0] mack, input logic [4:0] fack);
        chk(tag, "take", 32'(take), 32'd1);
        chk(tag, "vec", 32'(vec_addr), {16'h0000, lo});
        chk(tag, "mask_ack", 32'(mask_ack), 32'(mack));
        chk(tag, "fix_ack", 32'(fix_ack), 32'(fack));
    endtask

    task automatic t_reset();
        chk("R1", "take", 32'(take), 0);
        chk("R1", "vec", 32'(vec_addr), 0);
        chk("R1", "acks", 32'({mask_ack, fix_ack}), 0);
    endtask

    task automatic t_fixed_order();
        clr();
        irq_dis = 1; cur_ipl = 3'd7;
        rst_req = 1; dbg_req = 1; wdt_req = 1; zdiv_req = 1; brk_req = 1;
        set_src(0, 3'd7);
        step_take(); expect_take("R2", 16'hFFFE, '0, 5'b00001); idle();
        rst_req = 0;
        step_take(); expect_take("R2", 16'hFFF8, '0, 5'b00010); idle();
        dbg_req = 0;
        step_take(); expect_take("R2", 16'hFFF6, '0, 5'b00100); idle();
        wdt_req = 0;
        step_take(); expect_take("R2", 16'hFFFC, '0, 5'b01000); idle();
        zdiv_req = 0;
        step_take(); expect_take("R7", 16'hFFFA, '0, 5'b10000); idle();
        brk_req = 0; irq_dis = 0; cur_ipl = 0;
        step_take(); expect_take("R2", 16'hFFF4, 16'h0001, 5'b0); idle();
    endtask

    task automatic t_mask_gate();
        clr();
        set_src(4, 3'd3); cur_ipl = 3'd3;
        step_take(); chk("R3", "equal level not taken", 32'(take), 0); idle();
        cur_ipl = 3'd2;
        step_take(); expect_take("R3", 16'hFFEC, 16'h0010, 5'b0); idle();
        irq_dis = 1;
        step_take(); chk("R3", "disabled not taken", 32'(take), 0); idle();
        irq_dis = 0; cur_ipl = 0; mask_lvl = '0;
        step_take(); chk("R3", "level zero not taken", 32'(take), 0); idle();
    endtask

    task automatic t_levels();
        clr();
        set_src(2, 3'd5); set_src(10, 3'd6); set_src(15, 3'd6);
        step_take(); expect_take("R4", 16'hFFE0, 16'h0400, 5'b0); idle();
        clr();
        set_src(7, 3'd4); set_src(3, 3'd4); set_src(1, 3'd2);
        step_take(); expect_take("R4", 16'hFFEE, 16'h0008, 5'b0); idle();
    endtask

    task automatic t_vectors();
        for (int i = 0; i < N; i++) begin
            clr();
            set_src(i, 3'd7);
            step_take();
            expect_take("R5", 16'(16'hFFF4 - 2 * i), N'(1) << i, 5'b0);
            idle();
        end
    endtask

    task automatic t_take_off();
        logic [23:0] held;
        clr();
        held = vec_addr;
        rst_req = 1; set_src(0, 3'd7);
        for (int k = 0; k < 3; k++) begin
            idle();
            chk("R8", "no take while disabled", 32'(take), 0);
            chk("R9", "vec held", 32'(vec_addr), 32'(held));
        end
    endtask

    task automatic t_spacing();
        clr();
        dbg_req = 1; take_en = 1;
        @(posedge clk); @(negedge clk);
        expect_take("R6", 16'hFFF8, '0, 5'b00010);
        @(posedge clk); @(negedge clk);
        chk("R6", "gap cycle", 32'(take), 0);
        chk("R7", "no ack in gap", 32'({mask_ack, fix_ack}), 0);
        chk("R9", "vec held in gap", 32'(vec_addr), 32'h00FFF8);
        @(posedge clk); @(negedge clk);
        chk("R6", "retake", 32'(take), 1);
        clr();
        idle();
        chk("R6", "one-cycle strobe", 32'(take), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst = 0;
        idle();
        t_reset();
        t_fixed_order();
        t_mask_gate();
        t_levels();
        t_vectors();
        t_take_off();
        t_spacing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule